// File: doc/BRIEF.md
# Global 64-bit Compare Timer

This block is a memory-mapped timer for system timekeeping. A 64-bit up-counter runs freely once started and is presented on a 32-bit register interface as two separate halves, each of which software can preset. A single 64-bit comparator watches the counter. On an exact match it raises an interrupt status flag. In periodic mode the comparator then moves itself forward by a programmable increment, so a steady train of interrupts follows without any software action beyond clearing the status.

Every write to a value or control register is confirmed through a sticky write-status flag. Software polls this flag and clears it by writing a one to it. The two counter halves are not latched together. A coherent 64-bit read therefore needs the usual high, low, high sequence, repeated until both high reads agree. The interrupt output is a level signal, high while the status flag and the enable bit are both set.

Top module: `gcmp_timer`

## Requirements
- R1: After synchronous reset, every register reads zero. This covers counter, comparator, increment, control, interrupt status, interrupt enable and both write-status registers. `irq` is low.
- R2: A write to offset 0x100 replaces counter bits 31:0 and a write to 0x104 replaces bits 63:32. In that cycle the write takes priority over counting, and the other half is left as it was. Reads of the same offsets return the live halves.
- R3: While control bit 8 (offset 0x240) is set, the counter increases by one on each clock edge. It wraps from all ones to zero. While bit 8 is clear, the counter holds.
- R4: When control bit 0 is set and the counter equals the comparator exactly (all 64 bits), bit 0 of the interrupt status at 0x244 is set on the next edge. When control bit 0 is clear, no match is detected.
- R5: When control bit 1 is set, each match adds the increment register (0x208, zero-extended) to the comparator (0x200 low half, 0x204 high half). When bit 1 is clear, the comparator keeps its value after a match.
- R6: Writing 1 to bit 0 of 0x244 clears the interrupt status. Writing 0 leaves it unchanged.
- R7: `irq` is high exactly while the interrupt status bit and bit 0 of the interrupt enable register at 0x248 are both set.
- R8: On the edge that follows a write, the matching write-status bit is set. Offset 0x110 uses bit 0 for the counter low half and bit 1 for the counter high half. Offset 0x24C uses bit 0 for the comparator low half, bit 1 for the comparator high half, bit 2 for the increment and bit 16 for the control register. These bits stay set until cleared.
- R9: Writing a word to 0x110 or 0x24C clears the bits that are one in that word and leaves the other bits as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte offset of the register, used for both reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check the counter step, counter hold and wrap rules. They also check that the comparator changes only through a write or a match with auto-increment, and that the comparator gains exactly the increment when it does. For interrupt status they check that it rises only after a match and falls only after a clear write, and they check that a control write sets its write-status bit. The bench scenarios are needed to show the exact interrupt cycles of a periodic train and the gating of `irq` by the enable register. Only the scenarios show the write-one-to-clear behaviour of both status registers, a preset of the counter while it runs, and a wrap of the full 64-bit counter seen through the two read halves.

// File: rtl/gcmp_pkg.sv
package gcmp_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_CNT_LO  = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI  = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_CNT_WST = 12'h110;
    localparam logic [ADDR_W-1:0] OFS_CMP_LO  = 12'h200;
    localparam logic [ADDR_W-1:0] OFS_CMP_HI  = 12'h204;
    localparam logic [ADDR_W-1:0] OFS_CMP_INC = 12'h208;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 12'h240;
    localparam logic [ADDR_W-1:0] OFS_ISTAT   = 12'h244;
    localparam logic [ADDR_W-1:0] OFS_IEN     = 12'h248;
    localparam logic [ADDR_W-1:0] OFS_WST     = 12'h24C;

    localparam int CTRL_RUN_BIT  = 8;
    localparam int CTRL_AINC_BIT = 1;
    localparam int CTRL_CEN_BIT  = 0;

    localparam int WST_CMPLO_BIT = 0;
    localparam int WST_CMPHI_BIT = 1;
    localparam int WST_INC_BIT   = 2;
    localparam int WST_CTRL_BIT  = 16;

    typedef enum logic [3:0] {
        REG_NONE,
        REG_CNT_LO,
        REG_CNT_HI,
        REG_CNT_WST,
        REG_CMP_LO,
        REG_CMP_HI,
        REG_CMP_INC,
        REG_CTRL,
        REG_ISTAT,
        REG_IEN,
        REG_WST
    } reg_sel_e;

    typedef struct packed {
        logic run;
        logic auto_inc;
        logic cmp_en;
    } ctrl_t;

    typedef struct packed {
        logic cnt_lo;
        logic cnt_hi;
        logic cnt_wst;
        logic cmp_lo;
        logic cmp_hi;
        logic cmp_inc;
        logic ctrl;
        logic istat;
        logic ien;
        logic wst;
    } wr_strobe_t;

    function automatic reg_sel_e decode_reg(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_CNT_LO:  s = REG_CNT_LO;
            OFS_CNT_HI:  s = REG_CNT_HI;
            OFS_CNT_WST: s = REG_CNT_WST;
            OFS_CMP_LO:  s = REG_CMP_LO;
            OFS_CMP_HI:  s = REG_CMP_HI;
            OFS_CMP_INC: s = REG_CMP_INC;
            OFS_CTRL:    s = REG_CTRL;
            OFS_ISTAT:   s = REG_ISTAT;
            OFS_IEN:     s = REG_IEN;
            OFS_WST:     s = REG_WST;
            default:     s = REG_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gcmp_counter.sv
module gcmp_counter #(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [DATA_W-1:0]     wdata,
    output logic [2*DATA_W-1:0]   cnt
);
    localparam int CNT_W = 2 * DATA_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt[DATA_W-1:0]     <= wdata;
            if (wr_hi) cnt[CNT_W-1:DATA_W] <= wdata;
        end else if (run) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/gcmp_comparator.sv
module gcmp_comparator #(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmp_en,
    input  logic                  auto_inc,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic                  wr_inc,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [2*DATA_W-1:0]   cnt,
    output logic [2*DATA_W-1:0]   cmp,
    output logic [DATA_W-1:0]     inc,
    output logic                  match
);
    localparam int CNT_W  = 2 * DATA_W;
    localparam int HALVES = 2;

    logic [HALVES-1:0][DATA_W-1:0] cmp_h;
    logic [HALVES-1:0]             wr_h;
    logic [CNT_W-1:0]              cmp_sum;
    logic                          advance;

    assign wr_h    = {wr_hi, wr_lo};
    assign cmp     = cmp_h;
    assign match   = cmp_en && (cnt == cmp);
    assign cmp_sum = cmp + CNT_W'(inc);
    assign advance = match && auto_inc && !(|wr_h);

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_h[h] <= '0;
            end else if (wr_h[h]) begin
                cmp_h[h] <= wdata;
            end else if (advance) begin
                cmp_h[h] <= cmp_sum[h*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         inc <= '0;
        else if (wr_inc) inc <= wdata;
    end
endmodule

// File: rtl/gcmp_regif.sv
module gcmp_regif
    import gcmp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  match,
    input  logic [2*DATA_W-1:0]   cnt,
    input  logic [2*DATA_W-1:0]   cmp,
    input  logic [DATA_W-1:0]     inc,
    output wr_strobe_t            strb,
    output ctrl_t                 ctrl,
    output logic                  istat,
    output logic                  ien,
    output logic [DATA_W-1:0]     wst_g
);
    localparam int CNT_W = 2 * DATA_W;

    reg_sel_e          wsel;
    reg_sel_e          rsel;
    logic [1:0]        wst_c;
    logic [1:0]        wst_c_set;
    logic [1:0]        wst_c_clr;
    logic [DATA_W-1:0] wst_g_set;
    logic [DATA_W-1:0] wst_g_clr;

    assign wsel = bus_wr ? decode_reg(bus_addr) : REG_NONE;
    assign rsel = decode_reg(bus_addr);

    always_comb begin
        strb = '0;
        case (wsel)
            REG_CNT_LO:  strb.cnt_lo  = 1'b1;
            REG_CNT_HI:  strb.cnt_hi  = 1'b1;
            REG_CNT_WST: strb.cnt_wst = 1'b1;
            REG_CMP_LO:  strb.cmp_lo  = 1'b1;
            REG_CMP_HI:  strb.cmp_hi  = 1'b1;
            REG_CMP_INC: strb.cmp_inc = 1'b1;
            REG_CTRL:    strb.ctrl    = 1'b1;
            REG_ISTAT:   strb.istat   = 1'b1;
            REG_IEN:     strb.ien     = 1'b1;
            REG_WST:     strb.wst     = 1'b1;
            default:     strb         = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (strb.ctrl) begin
            ctrl.run      <= bus_wdata[CTRL_RUN_BIT];
            ctrl.auto_inc <= bus_wdata[CTRL_AINC_BIT];
            ctrl.cmp_en   <= bus_wdata[CTRL_CEN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            ien <= 1'b0;
        else if (strb.ien)  ien <= bus_wdata[0];
    end

    // set by a match wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)                            istat <= 1'b0;
        else if (match)                     istat <= 1'b1;
        else if (strb.istat && bus_wdata[0]) istat <= 1'b0;
    end

    assign wst_c_set = {strb.cnt_hi, strb.cnt_lo};
    assign wst_c_clr = strb.cnt_wst ? bus_wdata[1:0] : 2'b00;

    always_comb begin
        wst_g_set = '0;
        wst_g_set[WST_CMPLO_BIT] = strb.cmp_lo;
        wst_g_set[WST_CMPHI_BIT] = strb.cmp_hi;
        wst_g_set[WST_INC_BIT]   = strb.cmp_inc;
        wst_g_set[WST_CTRL_BIT]  = strb.ctrl;
    end
    assign wst_g_clr = strb.wst ? bus_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            wst_c <= '0;
            wst_g <= '0;
        end else begin
            wst_c <= (wst_c & ~wst_c_clr) | wst_c_set;
            wst_g <= (wst_g & ~wst_g_clr) | wst_g_set;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (rsel)
            REG_CNT_LO:  bus_rdata = cnt[DATA_W-1:0];
            REG_CNT_HI:  bus_rdata = cnt[CNT_W-1:DATA_W];
            REG_CNT_WST: bus_rdata = DATA_W'(wst_c);
            REG_CMP_LO:  bus_rdata = cmp[DATA_W-1:0];
            REG_CMP_HI:  bus_rdata = cmp[CNT_W-1:DATA_W];
            REG_CMP_INC: bus_rdata = inc;
            REG_CTRL: begin
                bus_rdata[CTRL_RUN_BIT]  = ctrl.run;
                bus_rdata[CTRL_AINC_BIT] = ctrl.auto_inc;
                bus_rdata[CTRL_CEN_BIT]  = ctrl.cmp_en;
            end
            REG_ISTAT:   bus_rdata[0] = istat;
            REG_IEN:     bus_rdata[0] = ien;
            REG_WST:     bus_rdata = wst_g;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gcmp_timer.sv
module gcmp_timer
    import gcmp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    wr_strobe_t        strb;
    ctrl_t             ctrl;
    logic              istat;
    logic              ien;
    logic              match;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cmp;
    logic [DATA_W-1:0] inc;
    logic [DATA_W-1:0] wst_g;

    gcmp_regif #(.DATA_W(DATA_W)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .match     (match),
        .cnt       (cnt),
        .cmp       (cmp),
        .inc       (inc),
        .strb      (strb),
        .ctrl      (ctrl),
        .istat     (istat),
        .ien       (ien),
        .wst_g     (wst_g)
    );

    gcmp_counter #(.DATA_W(DATA_W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl.run),
        .wr_lo (strb.cnt_lo),
        .wr_hi (strb.cnt_hi),
        .wdata (bus_wdata),
        .cnt   (cnt)
    );

    gcmp_comparator #(.DATA_W(DATA_W)) u_comparator (
        .clk      (clk),
        .rst      (rst),
        .cmp_en   (ctrl.cmp_en),
        .auto_inc (ctrl.auto_inc),
        .wr_lo    (strb.cmp_lo),
        .wr_hi    (strb.cmp_hi),
        .wr_inc   (strb.cmp_inc),
        .wdata    (bus_wdata),
        .cnt      (cnt),
        .cmp      (cmp),
        .inc      (inc),
        .match    (match)
    );

    assign irq = istat & ien;
endmodule

// File: rtl/gcmp_timer_chk.sv
module gcmp_timer_chk
    import gcmp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                clr_bit,
    input logic [2*DATA_W-1:0] cnt,
    input logic [2*DATA_W-1:0] cmp,
    input logic [DATA_W-1:0]   inc,
    input logic                match,
    input logic                run,
    input logic                auto_inc,
    input logic                cmp_en,
    input logic                istat,
    input logic                wst_ctrl
);
    localparam int CNT_W = 2 * DATA_W;

    logic cnt_wr;
    logic cmp_wr;
    logic ctrl_wr;
    logic istat_clr;

    assign cnt_wr    = bus_wr && (bus_addr == OFS_CNT_LO || bus_addr == OFS_CNT_HI);
    assign cmp_wr    = bus_wr && (bus_addr == OFS_CMP_LO || bus_addr == OFS_CMP_HI);
    assign ctrl_wr   = bus_wr && (bus_addr == OFS_CTRL);
    assign istat_clr = bus_wr && (bus_addr == OFS_ISTAT) && clr_bit;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && !$past(cnt_wr)) |-> cnt == $past(cnt) + CNT_W'(1)); // R3

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(run) && !$past(cnt_wr)) |-> $stable(cnt)); // R3

    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(cmp_wr) && !($past(match) && $past(auto_inc))) |-> $stable(cmp)); // R5

    AST_CMP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        ($past(match) && $past(auto_inc) && !$past(cmp_wr)) |-> cmp == $past(cmp) + CNT_W'($past(inc))); // R5

    AST_ISTAT_ROSE: assert property (@(posedge clk) disable iff (rst)
        $rose(istat) |-> ($past(cmp_en) && $past(cnt) == $past(cmp))); // R4

    AST_ISTAT_FELL: assert property (@(posedge clk) disable iff (rst)
        $fell(istat) |-> $past(istat_clr)); // R6

    AST_WST_CTRL: assert property (@(posedge clk) disable iff (rst)
        $past(ctrl_wr) |-> wst_ctrl); // R8
endmodule

bind gcmp_timer gcmp_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .clr_bit  (bus_wdata[0]),
    .cnt      (cnt),
    .cmp      (cmp),
    .inc      (inc),
    .match    (match),
    .run      (ctrl.run),
    .auto_inc (ctrl.auto_inc),
    .cmp_en   (ctrl.cmp_en),
    .istat    (istat),
    .wst_ctrl (wst_g[16])
);

// File: tb/gcmp_timer_tb.sv
`timescale 1ns/1ps
module gcmp_timer_tb;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;

    int     errors = 0;
    int     checks = 0;
    longint cyc = 0;
    int     exp_q[$];
    logic   irq_d = 1'b0;
    bit     done = 1'b0;

    gcmp_timer #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic wr(input logic [11:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [DW-1:0] d, output longint at);
        @(negedge clk);
        bus_addr = a;
        #1;
        d  = bus_rdata;
        at = cyc;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_irq(input string tag);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (irq) break;
        end
        if (!irq) chk(tag, 0, 1);
        @(posedge clk); #1;
    endtask

    // monitor: every rising edge of irq must match the next expected cycle
    always @(negedge clk) begin
        if (rst) begin
            irq_d <= 1'b0;
        end else begin
            if (irq && !irq_d) begin
                if (exp_q.size() == 0) begin
                    chk("R4/R7 unexpected irq rise at cycle", cyc, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk("R4/R5/R7 irq rise cycle", cyc, longint'(e));
                end
            end
            irq_d <= irq;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk("watchdog", 1, 0);
            summary();
        end
    end

    initial begin
        logic [DW-1:0] d;
        longint at, k, kw, kx;
        longint unsigned full;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        idle(1);

        // R1 reset state
        rd(12'h240, d, at); chk("R1 ctrl", d, 0);
        rd(12'h100, d, at); chk("R1 cnt lo", d, 0);
        rd(12'h104, d, at); chk("R1 cnt hi", d, 0);
        rd(12'h200, d, at); chk("R1 cmp lo", d, 0);
        rd(12'h208, d, at); chk("R1 inc", d, 0);
        rd(12'h244, d, at); chk("R1 istat", d, 0);
        rd(12'h24C, d, at); chk("R1 wst", d, 0);
        rd(12'h110, d, at); chk("R1 cnt wst", d, 0);
        chk("R1 irq", irq, 0);

        // R2 / R8 / R9 counter preset and its write status
        wr(12'h100, 32'h10);
        rd(12'h110, d, at); chk("R8 cnt wst lo", d, 1);
        rd(12'h100, d, at); chk("R2 cnt lo preset", d, 32'h10);
        wr(12'h104, 32'h0);
        rd(12'h110, d, at); chk("R8 cnt wst both", d, 3);
        wr(12'h110, 32'h1);
        rd(12'h110, d, at); chk("R9 cnt wst partial clear", d, 2);
        wr(12'h110, 32'h2);
        rd(12'h110, d, at); chk("R9 cnt wst cleared", d, 0);

        // comparator setup
        wr(12'h200, 32'h40);
        wr(12'h204, 32'h0);
        wr(12'h208, 32'h8);
        rd(12'h24C, d, at); chk("R8 wst cmp/inc", d, 7);
        wr(12'h24C, 32'h7);
        rd(12'h24C, d, at); chk("R9 wst cleared", d, 0);
        wr(12'h248, 32'h1);

        // periodic: run + auto-inc + compare enable
        wr(12'h240, 32'h103);
        k = cyc;
        exp_q.push_back(int'(k + 32'h31));
        exp_q.push_back(int'(k + 32'h39));
        exp_q.push_back(int'(k + 32'h41));
        rd(12'h24C, d, at); chk("R8 wst ctrl bit16", d, 32'h10000);
        rd(12'h100, d, at); chk("R3 counting", d, 32'h10 + (at - k));
        for (int i = 0; i < 3; i++) begin
            wait_irq("R5 periodic irq missing");
            wr(12'h244, 32'h1);
        end
        wr(12'h240, 32'h100);
        rd(12'h200, d, at); chk("R5 cmp advanced by increment", d, 32'h58);
        idle(40);
        chk("R4 no match while compare disabled", irq, 0);
        rd(12'h244, d, at); chk("R4 istat stays clear", d, 0);

        // one-shot with interrupt gating
        wr(12'h240, 32'h0);
        wr(12'h248, 32'h0);
        wr(12'h100, 32'h100);
        wr(12'h200, 32'h108);
        wr(12'h240, 32'h101);
        idle(20);
        rd(12'h244, d, at); chk("R4 match sets istat", d, 1);
        chk("R7 irq masked by enable", irq, 0);
        rd(12'h200, d, at); chk("R5 cmp unchanged without auto-inc", d, 32'h108);
        wr(12'h244, 32'h0);
        rd(12'h244, d, at); chk("R6 write zero keeps istat", d, 1);
        exp_q.push_back(int'(cyc + 1));
        wr(12'h248, 32'h1);
        chk("R7 irq follows enable", irq, 1);
        wr(12'h244, 32'h1);
        chk("R6 clear drops irq", irq, 0);
        rd(12'h244, d, at); chk("R6 istat cleared", d, 0);
        idle(10);
        chk("R4 single match event", irq, 0);

        // R2 preset while running
        wr(12'h100, 32'h500);
        kw = cyc;
        idle(3);
        rd(12'h100, d, at); chk("R2 write beats counting", d, 32'h500 + (at - kw));

        // R3 wrap of the full counter
        wr(12'h240, 32'h100);
        wr(12'h110, 32'h3);
        wr(12'h100, 32'hFFFF_FFFC);
        wr(12'h104, 32'hFFFF_FFFF);
        kx = cyc;
        rd(12'h110, d, at); chk("R8 cnt wst after preset", d, 3);
        idle(6);
        rd(12'h104, d, at);
        full = 64'hFFFF_FFFF_FFFF_FFFC + longint'(at - kx);
        chk("R3 wrap high half", d, full[63:32]);
        rd(12'h100, d, at);
        full = 64'hFFFF_FFFF_FFFF_FFFC + longint'(at - kx);
        chk("R3 wrap low half", d, full[31:0]);

        // R3 hold when stopped
        wr(12'h240, 32'h0);
        rd(12'h100, d, at);
        kw = longint'(d);
        idle(5);
        rd(12'h100, d, at); chk("R3 counter holds when stopped", d, kw);

        idle(2);
        chk("R4 all expected irq rises seen", exp_q.size(), 0);
        done = 1'b1;
        summary();
    end
endmodule